// File: doc/BRIEF.md
# Coprocessor and Port Transaction Sequencer

This block sits between a processor core and the shared, non-multiplexed 32-bit address and data bus. It carries out two kinds of off-core work: a coprocessor call, which hands a 32-bit command word and the accumulator to an external coprocessor, and an I/O port access, which reads from or writes to one of 2^32 port numbers. When the core strobes a request, the sequencer first stores the address and data values currently seen on the bus. Coprocessor calls and port accesses each have their own pair of save registers. It then drives the command or port number, the operand and a byte-enable pattern for the operand size, raises the matching select line, and waits.

The external agent opens the transaction by raising its bus request input and closes it by dropping that input. At the closing edge the sequencer samples the data bus, the byte enables and two side inputs. For a port input, the data goes to the accumulator, or to the Y register when the special-invocation input is high. When the RAM-assert input is high, a memory write request is issued with the address and data present on the bus. If no byte enable is set, nothing is written. If the agent never opens the transaction within a programmable number of cycles, the sequencer abandons it and raises an error flag. The active output stays high for as long as the core is held waiting.

Top module: `copro_port_seq`

## Requirements
- R1: After reset both selects are low, no bus output enable is set, read/write reads as 1 (read), active_n is 0, req_done and req_err are 0, and all four save registers hold zero.
- R2: A request is taken on a clock edge where req_valid is 1 and the block is idle. At that edge bus_addr_in and bus_data_in are stored into the coprocessor save pair when req_kind is 0 or 3, and into the port save pair when req_kind is 1 or 2. The other pair keeps its value.
- R3: From the cycle after a coprocessor request (req_kind 0) is taken, the block drives bus_addr_out = req_cmd and bus_data_out = accumulator with addr_oe and data_oe high, sets copro_sel to 1 and port_sel to 0, and sets bus_rw to 0 (write).
- R4: For a port request, port_sel is 1 and bus_addr_out is the port number. A port output (req_kind 1) drives the accumulator with bus_rw 0. A port input (req_kind 2) sets bus_rw to 1 and data_oe to 0.
- R5: While the request is being driven, be_out encodes req_size: 0 gives 4'b0001, 1 gives 4'b0011, and 2 or 3 gives 4'b1111.
- R6: The transaction opens on the first cycle breq is sampled high and completes on the first later edge where breq is sampled low. req_done is high for exactly the one cycle after that edge, and the selects drop in the same cycle.
- R7: On completion of a port input with nonzero be_in, acc_wr_en (or y_wr_en when spi_in is 1) pulses for one cycle, with wr_data = bus_data_in and wr_be = be_in as sampled at the completing edge. The two enables are never high together, and coprocessor or port output completions write no register.
- R8: When ram_assert is 1 at the completing edge and be_in is nonzero, mem_wr_en pulses for one cycle with wr_addr = bus_addr_in, wr_data = bus_data_in and wr_be = be_in from that edge.
- R9: When be_in is 4'b0000 at the completing edge, acc_wr_en, y_wr_en and mem_wr_en all stay 0, whatever ram_assert and spi_in are.
- R10: active_n is 1 in every cycle from the cycle after a request is taken until the cycle in which req_done is high, and 0 otherwise.
- R11: If breq is still low at the edge where the wait counter equals cfg_timeout, the transaction is abandoned. This happens on the (cfg_timeout+1)-th edge after the taking edge. req_done and req_err are then high, the selects drop, and req_err stays high until the next request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Single-cycle request strobe from the core |
| req_kind | input | 2 | 0 coprocessor, 1 port output, 2 port input, 3 as coprocessor |
| req_size | input | 2 | Operand size: 0 byte, 1 halfword, 2/3 word |
| req_cmd | input | 32 | Coprocessor command word or port number |
| req_acc | input | 32 | Accumulator value to send |
| cfg_timeout | input | 16 | Wait limit for the opening of breq, in cycles |
| req_done | output | 1 | One-cycle completion or abort pulse |
| req_err | output | 1 | Timeout error flag, cleared by the next request |
| bus_addr_in | input | 32 | Address bus as seen by the block |
| bus_data_in | input | 32 | Data bus as seen by the block |
| be_in | input | 4 | Byte enables returned by the agent |
| breq | input | 1 | Agent's transaction bracket |
| ram_assert | input | 1 | Request a memory write-back at completion |
| spi_in | input | 1 | Redirect input data to Y |
| bus_addr_out | output | 32 | Driven address value |
| bus_data_out | output | 32 | Driven data value |
| addr_oe | output | 1 | Address output enable |
| data_oe | output | 1 | Data output enable |
| bus_rw | output | 1 | 1 read, 0 write |
| be_out | output | 4 | Driven byte enables (operand size) |
| copro_sel | output | 1 | Coprocessor select |
| port_sel | output | 1 | Port select |
| active_n | output | 1 | High while the core waits on a transaction |
| acc_wr_en | output | 1 | Accumulator write pulse |
| y_wr_en | output | 1 | Y register write pulse |
| mem_wr_en | output | 1 | Memory write-back request pulse |
| wr_addr | output | 32 | Write-back address |
| wr_data | output | 32 | Register or memory write data |
| wr_be | output | 4 | Byte enables of the write |
| cop_save_addr | output | 32 | Saved address, coprocessor pair |
| cop_save_data | output | 32 | Saved data, coprocessor pair |
| port_save_addr | output | 32 | Saved address, port pair |
| port_save_data | output | 32 | Saved data, port pair |

## Verification
The assertions check on every cycle that a select is never raised while active_n is low, that completion and abort pulses last one cycle, that an abort is always followed by the error flag, that the accumulator and Y enables are never both set, that no write follows an all-zero byte-enable completion, and that a save pair changes only at the taking edge. Only the bench's scenarios can show that the driven command, port number, operand, direction and byte-enable pattern match the request. They also show that each kind routes its saved values into the right pair, that returned data reaches the right destination with the sampled address, and that the abort lands on exactly the edge set by cfg_timeout.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OPEN = 2'd2
  } cps_state_t;

  localparam logic [1:0] KIND_COP = 2'd0;
  localparam logic [1:0] KIND_OUT = 2'd1;
  localparam logic [1:0] KIND_IN  = 2'd2;

  // Port kinds use the port save pair; everything else is a coprocessor call.
  function automatic logic kind_is_port(input logic [1:0] k);
    return (k == KIND_OUT) || (k == KIND_IN);
  endfunction

  function automatic logic kind_drives_data(input logic [1:0] k);
    return k != KIND_IN;
  endfunction

  // Size code s selects 2**s low bytes, clipped to the bus width.
  function automatic logic [3:0] size_to_be(input logic [1:0] s);
    logic [3:0] be;
    for (int i = 0; i < 4; i++) be[i] = (i < (1 << s));
    return be;
  endfunction

endpackage

// File: rtl/cps_save_bank.sv
module cps_save_bank #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> ($stable(addr_q) && $stable(data_q)));

endmodule

// File: rtl/cps_ctrl.sv
module cps_ctrl
  import cps_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int BEW = DW / 8,
  parameter int TW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [1:0]     req_kind,
  input  logic [1:0]     req_size,
  input  logic [AW-1:0]  req_cmd,
  input  logic [DW-1:0]  req_acc,
  input  logic [TW-1:0]  cfg_timeout,
  input  logic           breq,
  output logic           accept_ev,
  output logic           done_ev,
  output logic           timeout_ev,
  output logic [1:0]     kind_q,
  output logic           req_done,
  output logic           req_err,
  output logic [AW-1:0]  bus_addr_out,
  output logic [DW-1:0]  bus_data_out,
  output logic           addr_oe,
  output logic           data_oe,
  output logic           bus_rw,
  output logic [BEW-1:0] be_out,
  output logic           copro_sel,
  output logic           port_sel,
  output logic           active_n
);

  cps_state_t      state, state_nx;
  logic [1:0]      size_q;
  logic [AW-1:0]   cmd_q;
  logic [DW-1:0]   acc_q;
  logic [TW-1:0]   wait_cnt;
  logic [3:0]      be_full;

  assign accept_ev  = (state == ST_IDLE) && req_valid;
  assign done_ev    = (state == ST_OPEN) && !breq;
  assign timeout_ev = (state == ST_WAIT) && !breq && (wait_cnt >= cfg_timeout);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (req_valid) state_nx = ST_WAIT;
      ST_WAIT: if (breq) state_nx = ST_OPEN;
               else if (timeout_ev) state_nx = ST_IDLE;
      ST_OPEN: if (!breq) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind_q   <= KIND_COP;
      size_q   <= '0;
      cmd_q    <= '0;
      acc_q    <= '0;
      wait_cnt <= '0;
      req_done <= 1'b0;
      req_err  <= 1'b0;
    end else begin
      state    <= state_nx;
      req_done <= done_ev || timeout_ev;
      if (accept_ev) begin
        kind_q   <= req_kind;
        size_q   <= req_size;
        cmd_q    <= req_cmd;
        acc_q    <= req_acc;
        wait_cnt <= '0;
        req_err  <= 1'b0;
      end else begin
        if (state == ST_WAIT) wait_cnt <= wait_cnt + 1'b1;
        if (timeout_ev) req_err <= 1'b1;
      end
    end
  end

  // Drive phase: only while waiting for the agent to open the transaction.
  logic driving, busy;
  assign driving = (state == ST_WAIT);
  assign busy    = (state != ST_IDLE);
  assign be_full = size_to_be(size_q);

  assign active_n     = busy;
  assign copro_sel    = busy && !kind_is_port(kind_q);
  assign port_sel     = busy && kind_is_port(kind_q);
  assign addr_oe      = driving;
  assign data_oe      = driving && kind_drives_data(kind_q);
  assign bus_addr_out = driving ? cmd_q : '0;
  assign bus_data_out = (driving && kind_drives_data(kind_q)) ? acc_q : '0;
  assign bus_rw       = !(driving && kind_drives_data(kind_q));
  assign be_out       = driving ? be_full[BEW-1:0] : '0;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  p_timeout_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_ev |=> (req_err && req_done && !copro_sel && !port_sel));

  p_sel_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (copro_sel || port_sel) |-> active_n);

  p_drive_one_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> (copro_sel ^ port_sel));

endmodule

// File: rtl/cps_complete.sv
module cps_complete
  import cps_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           done_ev,
  input  logic [1:0]     kind_q,
  input  logic [AW-1:0]  bus_addr_in,
  input  logic [DW-1:0]  bus_data_in,
  input  logic [BEW-1:0] be_in,
  input  logic           ram_assert,
  input  logic           spi_in,
  output logic           acc_wr_en,
  output logic           y_wr_en,
  output logic           mem_wr_en,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic [BEW-1:0] wr_be
);

  logic any_be, to_reg;
  assign any_be = |be_in;
  assign to_reg = done_ev && any_be && (kind_q == KIND_IN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_wr_en <= 1'b0;
      y_wr_en   <= 1'b0;
      mem_wr_en <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_be     <= '0;
    end else begin
      acc_wr_en <= to_reg && !spi_in;
      y_wr_en   <= to_reg && spi_in;
      mem_wr_en <= done_ev && any_be && ram_assert;
      if (done_ev) begin
        wr_addr <= bus_addr_in;
        wr_data <= bus_data_in;
        wr_be   <= be_in;
      end
    end
  end

  p_acc_y_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_wr_en && y_wr_en));

  p_no_be_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && !any_be) |=> !(acc_wr_en || y_wr_en || mem_wr_en));

endmodule

// File: rtl/copro_port_seq.sv
module copro_port_seq
  import cps_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int TW  = 16,
  localparam int BEW = DW / 8,
  localparam int NBANK = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [1:0]     req_kind,
  input  logic [1:0]     req_size,
  input  logic [AW-1:0]  req_cmd,
  input  logic [DW-1:0]  req_acc,
  input  logic [TW-1:0]  cfg_timeout,
  output logic           req_done,
  output logic           req_err,
  input  logic [AW-1:0]  bus_addr_in,
  input  logic [DW-1:0]  bus_data_in,
  input  logic [BEW-1:0] be_in,
  input  logic           breq,
  input  logic           ram_assert,
  input  logic           spi_in,
  output logic [AW-1:0]  bus_addr_out,
  output logic [DW-1:0]  bus_data_out,
  output logic           addr_oe,
  output logic           data_oe,
  output logic           bus_rw,
  output logic [BEW-1:0] be_out,
  output logic           copro_sel,
  output logic           port_sel,
  output logic           active_n,
  output logic           acc_wr_en,
  output logic           y_wr_en,
  output logic           mem_wr_en,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic [BEW-1:0] wr_be,
  output logic [AW-1:0]  cop_save_addr,
  output logic [DW-1:0]  cop_save_data,
  output logic [AW-1:0]  port_save_addr,
  output logic [DW-1:0]  port_save_data
);

  logic       accept_ev, done_ev, timeout_ev;
  logic [1:0] kind_q;
  logic [NBANK-1:0][AW-1:0] sv_addr;
  logic [NBANK-1:0][DW-1:0] sv_data;

  cps_ctrl #(.AW(AW), .DW(DW), .BEW(BEW), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_size(req_size),
    .req_cmd(req_cmd), .req_acc(req_acc), .cfg_timeout(cfg_timeout),
    .breq(breq),
    .accept_ev(accept_ev), .done_ev(done_ev), .timeout_ev(timeout_ev),
    .kind_q(kind_q), .req_done(req_done), .req_err(req_err),
    .bus_addr_out(bus_addr_out), .bus_data_out(bus_data_out),
    .addr_oe(addr_oe), .data_oe(data_oe), .bus_rw(bus_rw), .be_out(be_out),
    .copro_sel(copro_sel), .port_sel(port_sel), .active_n(active_n)
  );

  // Bank 0 holds the coprocessor pair, bank 1 the port pair.
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic cap;
    assign cap = accept_ev && (kind_is_port(req_kind) == (g == 1));
    cps_save_bank #(.AW(AW), .DW(DW)) u_bank (
      .clk(clk), .rst_n(rst_n), .cap_en(cap),
      .addr_in(bus_addr_in), .data_in(bus_data_in),
      .addr_q(sv_addr[g]), .data_q(sv_data[g])
    );
  end

  assign cop_save_addr  = sv_addr[0];
  assign cop_save_data  = sv_data[0];
  assign port_save_addr = sv_addr[1];
  assign port_save_data = sv_data[1];

  cps_complete #(.AW(AW), .DW(DW), .BEW(BEW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .done_ev(done_ev), .kind_q(kind_q),
    .bus_addr_in(bus_addr_in), .bus_data_in(bus_data_in), .be_in(be_in),
    .ram_assert(ram_assert), .spi_in(spi_in),
    .acc_wr_en(acc_wr_en), .y_wr_en(y_wr_en), .mem_wr_en(mem_wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
  );

  p_write_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr_en || y_wr_en || mem_wr_en) |-> req_done);

endmodule

// File: tb/copro_port_seq_bench.sv
module copro_port_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_cmd = '0;
  logic [31:0] req_acc = '0;
  logic [15:0] cfg_timeout = 16'd40;
  logic        req_done, req_err;
  logic [31:0] bus_addr_in = '0;
  logic [31:0] bus_data_in = '0;
  logic [3:0]  be_in = '0;
  logic        breq = 1'b0;
  logic        ram_assert = 1'b0;
  logic        spi_in = 1'b0;
  logic [31:0] bus_addr_out, bus_data_out;
  logic        addr_oe, data_oe, bus_rw;
  logic [3:0]  be_out;
  logic        copro_sel, port_sel, active_n;
  logic        acc_wr_en, y_wr_en, mem_wr_en;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;
  logic [31:0] cop_save_addr, cop_save_data, port_save_addr, port_save_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  copro_port_seq u_copro_port_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_size(req_size), .req_cmd(req_cmd), .req_acc(req_acc),
    .cfg_timeout(cfg_timeout), .req_done(req_done), .req_err(req_err),
    .bus_addr_in(bus_addr_in), .bus_data_in(bus_data_in), .be_in(be_in),
    .breq(breq), .ram_assert(ram_assert), .spi_in(spi_in),
    .bus_addr_out(bus_addr_out), .bus_data_out(bus_data_out),
    .addr_oe(addr_oe), .data_oe(data_oe), .bus_rw(bus_rw), .be_out(be_out),
    .copro_sel(copro_sel), .port_sel(port_sel), .active_n(active_n),
    .acc_wr_en(acc_wr_en), .y_wr_en(y_wr_en), .mem_wr_en(mem_wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .cop_save_addr(cop_save_addr), .cop_save_data(cop_save_data),
    .port_save_addr(port_save_addr), .port_save_data(port_save_data)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] exp_be(input logic [1:0] s);
    case (s)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // Strobe one request, with the given bus values present at the taking edge.
  task automatic issue(input logic [1:0] k, input logic [1:0] s,
                       input logic [31:0] cmd, input logic [31:0] acc,
                       input logic [31:0] ba, input logic [31:0] bd);
    req_kind = k; req_size = s; req_cmd = cmd; req_acc = acc;
    bus_addr_in = ba; bus_data_in = bd; req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
  endtask

  // Open then close the transaction with the given return values.
  task automatic finish_txn(input logic [31:0] ra, input logic [31:0] rd,
                            input logic [3:0] be, input logic ram, input logic spi);
    breq = 1'b1;
    tick();
    chk("R6", "no done while open", {31'd0, req_done}, 32'd0);
    chk("R10", "active_n while open", {31'd0, active_n}, 32'd1);
    bus_addr_in = ra; bus_data_in = rd; be_in = be; ram_assert = ram; spi_in = spi;
    breq = 1'b0;
    tick();
    chk("R6", "done pulse", {31'd0, req_done}, 32'd1);
    chk("R6", "selects dropped", {30'd0, copro_sel, port_sel}, 32'd0);
    chk("R10", "active_n after done", {31'd0, active_n}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "selects", {30'd0, copro_sel, port_sel}, 32'd0);
    chk("R1", "oe", {30'd0, addr_oe, data_oe}, 32'd0);
    chk("R1", "rw read", {31'd0, bus_rw}, 32'd1);
    chk("R1", "active_n", {31'd0, active_n}, 32'd0);
    chk("R1", "done/err", {30'd0, req_done, req_err}, 32'd0);
    chk("R1", "saves", cop_save_addr | cop_save_data | port_save_addr | port_save_data, 32'd0);
  endtask

  task automatic t_coproc();
    issue(2'd0, 2'd2, 32'hC0DE_0102, 32'hAAAA_5555, 32'h1111_2222, 32'h3333_4444);
    chk("R2", "cop save addr", cop_save_addr, 32'h1111_2222);
    chk("R2", "cop save data", cop_save_data, 32'h3333_4444);
    chk("R2", "port pair untouched", port_save_addr, 32'd0);
    chk("R3", "addr out", bus_addr_out, 32'hC0DE_0102);
    chk("R3", "data out", bus_data_out, 32'hAAAA_5555);
    chk("R3", "sel/rw/oe", {27'd0, copro_sel, port_sel, bus_rw, addr_oe, data_oe}, 32'b10011);
    chk("R5", "be word", {28'd0, be_out}, {28'd0, exp_be(2'd2)});
    chk("R10", "active_n waiting", {31'd0, active_n}, 32'd1);
    finish_txn(32'h0000_8000, 32'hFEED_BEEF, 4'b1111, 1'b1, 1'b0);
    chk("R8", "mem write", {31'd0, mem_wr_en}, 32'd1);
    chk("R8", "mem addr", wr_addr, 32'h0000_8000);
    chk("R8", "mem data", wr_data, 32'hFEED_BEEF);
    chk("R7", "no reg write on coproc", {30'd0, acc_wr_en, y_wr_en}, 32'd0);
    tick();
    chk("R6", "done one cycle", {31'd0, req_done}, 32'd0);
    chk("R8", "mem pulse one cycle", {31'd0, mem_wr_en}, 32'd0);
  endtask

  task automatic t_port_out();
    issue(2'd1, 2'd0, 32'h0000_0020, 32'h0000_00A5, 32'h5555_0000, 32'h6666_0000);
    chk("R2", "port save addr", port_save_addr, 32'h5555_0000);
    chk("R2", "port save data", port_save_data, 32'h6666_0000);
    chk("R2", "cop pair kept", cop_save_addr, 32'h1111_2222);
    chk("R4", "port number", bus_addr_out, 32'h0000_0020);
    chk("R4", "out data", bus_data_out, 32'h0000_00A5);
    chk("R4", "sel/rw", {29'd0, copro_sel, port_sel, bus_rw}, 32'b010);
    chk("R5", "be byte", {28'd0, be_out}, {28'd0, exp_be(2'd0)});
    finish_txn(32'h0, 32'h1234_5678, 4'b0001, 1'b0, 1'b0);
    chk("R7", "no reg write on output", {29'd0, acc_wr_en, y_wr_en, mem_wr_en}, 32'd0);
    tick();
  endtask

  task automatic t_port_in(input logic spi);
    issue(2'd2, 2'd1, 32'h0000_0021, 32'hDEAD_DEAD, 32'h7777_0000, 32'h8888_0000);
    chk("R4", "in rw read", {31'd0, bus_rw}, 32'd1);
    chk("R4", "in data_oe low", {31'd0, data_oe}, 32'd0);
    chk("R5", "be half", {28'd0, be_out}, {28'd0, exp_be(2'd1)});
    finish_txn(32'h0000_4000, 32'h0000_BEAD, 4'b0011, 1'b0, spi);
    chk("R7", "acc write", {31'd0, acc_wr_en}, {31'd0, !spi});
    chk("R7", "y write", {31'd0, y_wr_en}, {31'd0, spi});
    chk("R7", "write data", wr_data, 32'h0000_BEAD);
    chk("R7", "write be", {28'd0, wr_be}, 32'h3);
    chk("R8", "no mem without ram_assert", {31'd0, mem_wr_en}, 32'd0);
    tick();
    spi_in = 1'b0;
  endtask

  task automatic t_zero_be();
    issue(2'd2, 2'd2, 32'h0000_0030, 32'h0, 32'h0, 32'h0);
    finish_txn(32'h0000_9000, 32'hFFFF_FFFF, 4'b0000, 1'b1, 1'b0);
    chk("R9", "no writes with zero be", {29'd0, acc_wr_en, y_wr_en, mem_wr_en}, 32'd0);
    tick();
    ram_assert = 1'b0;
  endtask

  task automatic t_timeout();
    cfg_timeout = 16'd5;
    issue(2'd0, 2'd2, 32'h0BAD_0001, 32'h1, 32'h9, 32'h9);
    for (int i = 0; i < 5; i++) tick();
    chk("R11", "still waiting at limit-1", {30'd0, req_done, active_n}, 32'b01);
    tick();
    chk("R11", "abort done", {31'd0, req_done}, 32'd1);
    chk("R11", "err set", {31'd0, req_err}, 32'd1);
    chk("R11", "sel dropped", {31'd0, copro_sel}, 32'd0);
    tick();
    tick();
    chk("R11", "err sticky", {31'd0, req_err}, 32'd1);
    cfg_timeout = 16'd40;
    issue(2'd1, 2'd0, 32'h22, 32'h0, 32'h0, 32'h0);
    chk("R11", "err cleared on new request", {31'd0, req_err}, 32'd0);
    finish_txn(32'h0, 32'h0, 4'b0001, 1'b0, 1'b0);
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_coproc();
    t_port_out();
    t_port_in(1'b0);
    t_port_in(1'b1);
    t_zero_be();
    t_timeout();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule